// File: doc/BRIEF.md
# Supervisor Domain Interrupt Aggregator

This block sits beside one hart's register file. It gathers the external-interrupt pending lines of the supervisor domains that are not running on the hart into a single local interrupt. Two per-domain registers do the work. The pending register follows the domain lines and software cannot write it. The enable register is written by software and picks which domains may raise the local interrupt. The OR of their bitwise AND is the summary. The summary appears at bit 16 of a machine pending view. It appears at bit 16 of a supervisor pending view only when the interrupt has been handed down to S-mode.

The block also holds a small configuration field that names which domain interrupt controller drives the hart's S-level and VS-level external-interrupt lines. Controller numbers run from 1 up to the `NUM_CTRL` parameter. The value 0 selects no controller. With `NUM_CTRL` = 0 the field is a constant zero.

All register access goes through one simple port with a 4-bit selector. A write takes effect at the next rising clock edge. Reads are combinational. The block has no state machine: its only states are the register contents listed below. Every register resets to zero on the active-low asynchronous reset.

Top module: `sdagg_top`

## Requirements
- R1: The domain-pending register (selector 0) holds the value that `dom_pend_i` had at the previous rising edge. A write to selector 0 does not change what selector 0 reads back.
- R2: The domain-enable register (selector 1) is read/write. It keeps the low `NUM_DOM` bits of the written data, and the bits above `NUM_DOM` read as zero.
- R3: The machine pending view (selector 3) reads bit 16 as 1 exactly when (pending AND enable) is nonzero, and reads every other bit as zero. `lsum_o` carries the same summary.
- R4: Writes to the machine pending view (selector 3) and to the supervisor pending view (selector 5) have no effect on any register.
- R5: The machine enable view (selector 4) holds one read/write bit at position 16. All of its other bits read as zero.
- R6: The supervisor pending view (selector 5) and the supervisor enable view (selector 6) show the summary bit and the enable bit at bit 16 only while the delegation bit is 1. Otherwise they read as zero. A write to selector 6 changes the enable bit only while the delegation bit is 1.
- R7: The machine delegation register (selector 7) holds one read/write bit at position 16. The hypervisor delegation register (selector 8) always reads as zero and ignores writes. Selectors 9 to 15 read as zero.
- R8: `m_irq_o` = summary AND enable bit AND NOT delegation bit. `s_irq_o` = summary AND enable bit AND delegation bit.
- R9: The controller-select field (selector 2, bits 7:0) accepts a written value from 0 to `NUM_CTRL`. A write of a larger value leaves the field unchanged.
- R10: With field value n ≥ 1, `seip_o` and `vseip_o` follow bit n−1 of `ctl_seip_i` and `ctl_vseip_i`. With n = 0 both outputs are 0. The domain-enable register has no effect on either output.
- R11: When `NUM_CTRL` = 0, the controller-select field reads as zero after any write, and `seip_o` and `vseip_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe, sampled at the rising edge |
| csr_addr | input | 4 | Register selector |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data for `csr_addr` |
| dom_pend_i | input | NUM_DOM | External-interrupt pending line of each domain |
| ctl_seip_i | input | NCI | S-level external-interrupt line of each controller (controller n on bit n−1) |
| ctl_vseip_i | input | NCI | VS-level external-interrupt line of each controller |
| seip_o | output | 1 | S-level external interrupt from the selected controller |
| vseip_o | output | 1 | VS-level external interrupt from the selected controller |
| lsum_o | output | 1 | Summary: (pending AND enable) is nonzero |
| m_irq_o | output | 1 | Local interrupt kept at machine level |
| s_irq_o | output | 1 | Local interrupt delegated to S-mode |

`NCI` is `NUM_CTRL` when `NUM_CTRL` is nonzero, and 1 otherwise.

## Verification
The summary is driven with random pending words and random enable masks, including single-bit overlaps and disjoint masks. This separates an OR-of-AND reduction from a plain OR of pending or a check of enable alone. The delegation bit is toggled while the summary is asserted, which shows whether each of the two views and the two interrupt outputs picks the right side. The controller-select field is written with values at, just above and far above the bound. Those writes run while the controller lines carry distinct patterns and while the enable register changes, so a wrong index, a missing bound check or a dependence on enable shows up on `seip_o` and `vseip_o`.

// File: rtl/sdagg_pkg.sv
package sdagg_pkg;

    // Register selector codes seen on csr_addr
    typedef enum logic [3:0] {
        SEL_DPEND  = 4'd0,
        SEL_DENA   = 4'd1,
        SEL_CFG    = 4'd2,
        SEL_MPEND  = 4'd3,
        SEL_MENA   = 4'd4,
        SEL_SPEND  = 4'd5,
        SEL_SENA   = 4'd6,
        SEL_MDELEG = 4'd7,
        SEL_HDELEG = 4'd8
    } csr_sel_e;

    // Bit position of the local summary interrupt in the shared views
    localparam int LIRQ_BIT = 16;
    localparam int XW       = 32;
    localparam int CFGW     = 8;

endpackage

// File: rtl/sdagg_dombank.sv
module sdagg_dombank #(
    parameter int NUM_DOM = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] dom_pend_i,
    input  logic               ena_we,
    input  logic [NUM_DOM-1:0] ena_wdata,
    output logic [NUM_DOM-1:0] pend_q,
    output logic [NUM_DOM-1:0] ena_q,
    output logic               summary_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= dom_pend_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (ena_we) begin
            ena_q <= ena_wdata;
        end
    end

    always_comb begin
        summary_o = |(pend_q & ena_q);
    end

    // R1
    pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_q == $past(dom_pend_i)));

    // R2
    ena_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ena_we |=> (ena_q == $past(ena_wdata)));

endmodule

// File: rtl/sdagg_ctlsel.sv
module sdagg_ctlsel #(
    parameter int NUM_CTRL = 5,
    parameter int NCI      = (NUM_CTRL > 0) ? NUM_CTRL : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [sdagg_pkg::CFGW-1:0] cfg_wdata,
    input  logic [NCI-1:0]            ctl_seip_i,
    input  logic [NCI-1:0]            ctl_vseip_i,
    output logic [sdagg_pkg::CFGW-1:0] sel_o,
    output logic                      seip_o,
    output logic                      vseip_o
);
    import sdagg_pkg::*;

    localparam logic [CFGW-1:0] SEL_MAX = CFGW'(NUM_CTRL);

    generate
        if (NUM_CTRL > 0) begin : g_ctl
            logic [CFGW-1:0] sel_q;

            // Bounded field: out-of-range writes keep the old value
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sel_q <= '0;
                end else if (cfg_we && (cfg_wdata <= SEL_MAX)) begin
                    sel_q <= cfg_wdata;
                end
            end

            always_comb begin
                seip_o  = 1'b0;
                vseip_o = 1'b0;
                for (int k = 0; k < NUM_CTRL; k++) begin
                    if (sel_q == CFGW'(k + 1)) begin
                        seip_o  = ctl_seip_i[k];
                        vseip_o = ctl_vseip_i[k];
                    end
                end
            end

            assign sel_o = sel_q;

            // R9
            sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && (cfg_wdata > SEL_MAX)) |=> $stable(sel_q));

            // R9
            sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sel_q <= SEL_MAX);

            // R10
            noctl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_q == '0) |-> (!seip_o && !vseip_o));
        end else begin : g_none
            logic unused_ctl_ins;
            assign unused_ctl_ins = ^{clk, rst_n, cfg_we, cfg_wdata, ctl_seip_i, ctl_vseip_i};
            assign sel_o   = '0;
            assign seip_o  = 1'b0;
            assign vseip_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sdagg_top.sv
module sdagg_top #(
    parameter  int NUM_DOM  = 24,
    parameter  int NUM_CTRL = 5,
    localparam int NCI      = (NUM_CTRL > 0) ? NUM_CTRL : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [3:0]         csr_addr,
    input  logic [31:0]        csr_wdata,
    output logic [31:0]        csr_rdata,
    input  logic [NUM_DOM-1:0] dom_pend_i,
    input  logic [NCI-1:0]     ctl_seip_i,
    input  logic [NCI-1:0]     ctl_vseip_i,
    output logic               seip_o,
    output logic               vseip_o,
    output logic               lsum_o,
    output logic               m_irq_o,
    output logic               s_irq_o
);
    import sdagg_pkg::*;

    logic [NUM_DOM-1:0] pend_q;
    logic [NUM_DOM-1:0] ena_q;
    logic               summary;
    logic [CFGW-1:0]    sel;
    logic               lie_q;     // local interrupt enable, bit 16
    logic               ldeleg_q;  // delegation to S-mode, bit 16
    logic               wr_dena, wr_cfg, wr_mena, wr_sena, wr_mdeleg;
    logic               unused_wbits;

    assign unused_wbits = ^csr_wdata;

    always_comb begin
        wr_dena   = csr_we && (csr_addr == SEL_DENA);
        wr_cfg    = csr_we && (csr_addr == SEL_CFG);
        wr_mena   = csr_we && (csr_addr == SEL_MENA);
        wr_sena   = csr_we && (csr_addr == SEL_SENA);
        wr_mdeleg = csr_we && (csr_addr == SEL_MDELEG);
    end

    sdagg_dombank #(.NUM_DOM(NUM_DOM)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .dom_pend_i(dom_pend_i),
        .ena_we    (wr_dena),
        .ena_wdata (csr_wdata[NUM_DOM-1:0]),
        .pend_q    (pend_q),
        .ena_q     (ena_q),
        .summary_o (summary)
    );

    sdagg_ctlsel #(.NUM_CTRL(NUM_CTRL), .NCI(NCI)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (wr_cfg),
        .cfg_wdata  (csr_wdata[CFGW-1:0]),
        .ctl_seip_i (ctl_seip_i),
        .ctl_vseip_i(ctl_vseip_i),
        .sel_o      (sel),
        .seip_o     (seip_o),
        .vseip_o    (vseip_o)
    );

    // Local enable: writable from the machine view, and from the
    // supervisor view only while delegated
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lie_q <= 1'b0;
        end else if (wr_mena || (wr_sena && ldeleg_q)) begin
            lie_q <= csr_wdata[LIRQ_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ldeleg_q <= 1'b0;
        end else if (wr_mdeleg) begin
            ldeleg_q <= csr_wdata[LIRQ_BIT];
        end
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            SEL_DPEND:  csr_rdata = XW'(pend_q);
            SEL_DENA:   csr_rdata = XW'(ena_q);
            SEL_CFG:    csr_rdata = XW'(sel);
            SEL_MPEND:  csr_rdata[LIRQ_BIT] = summary;
            SEL_MENA:   csr_rdata[LIRQ_BIT] = lie_q;
            SEL_SPEND:  csr_rdata[LIRQ_BIT] = summary && ldeleg_q;
            SEL_SENA:   csr_rdata[LIRQ_BIT] = lie_q && ldeleg_q;
            SEL_MDELEG: csr_rdata[LIRQ_BIT] = ldeleg_q;
            default:    csr_rdata = '0;
        endcase
    end

    always_comb begin
        lsum_o  = summary;
        m_irq_o = summary && lie_q && !ldeleg_q;
        s_irq_o = summary && lie_q && ldeleg_q;
    end

    // R6
    sena_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sena && !ldeleg_q && !wr_mena) |=> $stable(lie_q));

    // R8
    irq_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_irq_o && s_irq_o));

endmodule

// File: tb/sdagg_top_tb.sv
module sdagg_top_tb;
    localparam int ND = 24;
    localparam int NC = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic [3:0]    csr_addr = '0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata, rdata0;
    logic [ND-1:0] dom_pend = '0;
    logic [NC-1:0] cseip = '0, cvseip = '0;
    logic          seip, vseip, lsum, mirq, sirq;
    logic          seip0, vseip0, lsum0, mirq0, sirq0;
    logic [0:0]    c0s = 1'b1, c0v = 1'b1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // model state
    logic [ND-1:0] m_pend = '0, m_ena = '0;
    logic          m_lie = 0, m_deleg = 0;
    logic [7:0]    m_sel = '0;

    always #5 clk = ~clk;

    sdagg_top #(.NUM_DOM(ND), .NUM_CTRL(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dom_pend_i(dom_pend),
        .ctl_seip_i(cseip), .ctl_vseip_i(cvseip), .seip_o(seip), .vseip_o(vseip),
        .lsum_o(lsum), .m_irq_o(mirq), .s_irq_o(sirq));

    sdagg_top #(.NUM_DOM(ND), .NUM_CTRL(0)) u_dut0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(rdata0), .dom_pend_i(dom_pend),
        .ctl_seip_i(c0s), .ctl_vseip_i(c0v), .seip_o(seip0), .vseip_o(vseip0),
        .lsum_o(lsum0), .m_irq_o(mirq0), .s_irq_o(sirq0));

    function automatic logic f_sum();
        return |(m_pend & m_ena);
    endfunction

    function automatic logic [31:0] f_read(input logic [3:0] a);
        logic [31:0] r = '0;
        case (a)
            4'd0: r = 32'(m_pend);
            4'd1: r = 32'(m_ena);
            4'd2: r = 32'(m_sel);
            4'd3: r[16] = f_sum();
            4'd4: r[16] = m_lie;
            4'd5: r[16] = f_sum() & m_deleg;
            4'd6: r[16] = m_lie & m_deleg;
            4'd7: r[16] = m_deleg;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic f_seip(input logic [NC-1:0] v);
        return (m_sel == 0) ? 1'b0 : v[m_sel - 8'd1];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R9";
            4'd3: return "R3";
            4'd4: return "R5";
            4'd5, 4'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_all();
        for (int a = 0; a < 16; a++) begin
            csr_addr = 4'(a);
            #0.5;
            check(tag_of(4'(a)), csr_rdata, f_read(4'(a)));
        end
        check("R3", {31'd0, lsum}, {31'd0, f_sum()});
        check("R8", {30'd0, mirq, sirq},
              {30'd0, f_sum() & m_lie & ~m_deleg, f_sum() & m_lie & m_deleg});
        check("R10", {30'd0, seip, vseip}, {30'd0, f_seip(cseip), f_seip(cvseip)});
    endtask

    // one clock with optional write; inputs set at negedge
    task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d,
                        input logic [ND-1:0] p);
        @(negedge clk);
        csr_we = we; csr_addr = a; csr_wdata = d; dom_pend = p;
        @(posedge clk);
        m_pend = p;
        if (we) begin
            case (a)
                4'd1: m_ena = d[ND-1:0];
                4'd2: if (d[7:0] <= 8'(NC)) m_sel = d[7:0];
                4'd4: m_lie = d[16];
                4'd6: if (m_deleg) m_lie = d[16];
                4'd7: m_deleg = d[16];
                default: ;
            endcase
        end
        #1;
        csr_we = 1'b0;
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        check_all();                       // reset state
        rst_n = 1'b1;

        // R2: upper bits dropped
        step(1, 4'd1, 32'hFFFF_FFFF, '0); check_all();
        // R1/R4: writes to pending and pending views ignored
        step(1, 4'd0, 32'h00AB_CDEF, 24'h000100); check_all();
        step(1, 4'd3, 32'h0001_0000, 24'h000100); check_all();
        step(1, 4'd5, 32'h0000_0000, 24'h000100); check("R4", csr_rdata, f_read(csr_addr)); check_all();
        // R3: disjoint masks give no summary
        step(1, 4'd1, 32'h0000_00F0, 24'h00000F); check_all();
        step(0, 4'd0, 0, 24'h000010); check_all();
        // R5/R8: enable and machine-level interrupt
        step(1, 4'd4, 32'h0001_0000, 24'h000010); check_all();
        // R6: supervisor enable write while not delegated is ignored
        step(1, 4'd6, 32'h0000_0000, 24'h000010); check("R6", {31'd0, mirq}, 32'd1); check_all();
        // R7: delegate, then hypervisor write ignored
        step(1, 4'd7, 32'h0001_0000, 24'h000010); check_all();
        step(1, 4'd8, 32'hFFFF_FFFF, 24'h000010); check("R7", csr_rdata, 32'd0); check_all();
        step(1, 4'd6, 32'h0000_0000, 24'h000010); check_all();
        // R9/R10: bound cases
        cseip = 5'b10110; cvseip = 5'b01001;
        step(1, 4'd2, 32'd5, 0); check_all();
        step(1, 4'd2, 32'd6, 0); check("R9", csr_rdata, 32'd5); check_all();
        step(1, 4'd2, 32'd200, 0); check_all();
        step(1, 4'd2, 32'd1, 0); check_all();
        step(1, 4'd1, 32'd0, 0); check("R10", {31'd0, vseip}, 32'd1); check_all();
        step(1, 4'd2, 32'd0, 0); check_all();
        // R11: no controllers -> field zero
        step(1, 4'd2, 32'd0, 0);
        step(1, 4'd2, 32'd1, 0);
        csr_addr = 4'd2; #0.5;
        check("R11", rdata0, 32'd0);
        check("R11", {30'd0, seip0, vseip0}, 32'd0);

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  a;
            logic [31:0] d;
            logic [ND-1:0] p;
            a = 4'($urandom_range(0, 9));
            d = $urandom;
            if (a == 4'd2) d = 32'($urandom_range(0, 9));
            p = ND'($urandom) & ND'($urandom);
            cseip = NC'($urandom); cvseip = NC'($urandom);
            step(($urandom_range(0, 3) != 0), a, d, p);
            check_all();
            csr_addr = 4'd2; #0.5;
            check("R11", rdata0, 32'd0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule